// File: doc/BRIEF.md
# Sv32 Page Table Walker with Hardware Accessed/Dirty Update

This block translates a 32-bit virtual address into a 34-bit physical address by walking a two-level Sv32 page table held in memory. A request carries the virtual address, a load/store flag and the page number of the root table. The walker then reads one or two page table entries through a single-port memory interface and answers with a one-cycle completion pulse. That pulse carries either a physical address or a page-fault flag.

When the walker reaches a usable leaf whose accessed bit is clear, it does not trap. It also does not trap when a store finds the dirty bit clear. In both cases it sets the missing bit or bits and writes the entry back to the address it was read from, then completes the access. Faults are reserved for failures that software must handle: invalid entries, reserved encodings, misaligned superpages, a missing leaf, and permission mismatches.

The memory port is a single synchronous port. A read issued with `mem_req` high and `mem_we` low in one cycle must return its data on `mem_rdata` in the next cycle. A write with `mem_we` high lands at that clock edge.

Top module: `sv32_walker`

## Requirements
- R1: The level-1 entry is read at root_ppn*4096 + VA[31:22]*4. A non-leaf level-1 entry leads to the level-0 entry at PTE[31:10]*4096 + VA[21:12]*4. The entry bits are V=bit 0, R=bit 1, W=bit 2, X=bit 3, A=bit 6, D=bit 7, and the page number sits in bits 31:10.
- R2: A level-0 leaf yields the physical address {PTE[31:10], VA[11:0]}. A level-1 leaf is a 4 MiB superpage and yields {PTE[31:20], VA[21:0]}.
- R3: A valid, permitted leaf with A=0 gets A set and written back to memory, and the access completes with no fault.
- R4: A store to a permitted leaf with D=0 sets D in the written entry. A load never changes D. A store that finds both A and D clear sets both in one single write.
- R5: The write-back goes to the same address the entry was read from. It changes no bit other than A and D.
- R6: No write is issued when the required bits are already set, and a faulting walk writes nothing.
- R7: A fault is raised at any level for V=0 or for W=1 with R=0. A fault is also raised for a leaf load with R=0 and for a leaf store with W=0.
- R8: A non-leaf entry (R=X=0) at level 0 faults. A level-1 leaf whose PTE[19:10] is nonzero faults.
- R9: `done` is high for exactly one cycle per walk. A walk issues at most two reads. Requests that arrive while `busy` is high are ignored.
- R10: After reset `done`, `busy`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load access |
| root_ppn | input | 22 | Page number of the root table |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 34 | Byte address of the entry |
| mem_wdata | output | 32 | Entry written back |
| mem_rdata | input | 32 | Entry read, valid the cycle after a read strobe |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Page fault, valid with done |
| paddr | output | 34 | Physical address, valid with done when no fault |

## Verification
The bound checker watches every write-back on every cycle. It checks that the write goes to the address of the preceding read, that only A and D differ from the entry as it was read, that A is always set, that D follows the access type, and that no redundant write occurs. It also checks that `done` is a single pulse and that a walk never issues more than two reads. Two things only the bench's sweeps can show: that the fault decision and the physical address are correct for every combination of the low eight entry bits, at both levels and for both access types, and that misaligned superpages fault. The bench also shows that the final memory contents match what the arithmetic model predicts.

// File: rtl/sv32_pkg.sv
`timescale 1ns/1ps
package sv32_pkg;
  // Entry flag bit positions (fixed by the page-table format)
  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W = 2;
  localparam int PTE_X = 3;
  localparam int PTE_A = 6;
  localparam int PTE_D = 7;

  typedef enum logic [1:0] {
    VD_FAULT,
    VD_DESCEND,
    VD_LEAF,
    VD_LEAF_UPD
  } verdict_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_L1_RD,
    S_L1_CHK,
    S_L1_WB,
    S_L0_RD,
    S_L0_CHK,
    S_L0_WB,
    S_DONE
  } walk_state_t;
endpackage

// File: rtl/sv32_ent_addr.sv
`timescale 1ns/1ps
module sv32_ent_addr #(
  parameter int PPN_W = 22,
  parameter int VPN_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] tbl_ppn,
  input  logic [VPN_W-1:0] vpn_idx,
  output logic [PA_W-1:0]  ent_addr
);
  // table base (page aligned) plus a 4-byte slot per index
  assign ent_addr = (PA_W'(tbl_ppn) << OFF_W) + (PA_W'(vpn_idx) << 2);
endmodule

// File: rtl/sv32_pte_eval.sv
`timescale 1ns/1ps
module sv32_pte_eval
  import sv32_pkg::*;
#(
  parameter int PTE_BITS = 32,
  parameter int PPN_W    = 22,
  parameter int VPN_W    = 10
) (
  input  logic [PTE_BITS-1:0] pte,
  input  logic                is_store,
  input  logic                at_l0,
  output verdict_t            verdict,
  output logic [PTE_BITS-1:0] pte_new
);
  localparam int PPN_LSB = PTE_BITS - PPN_W;

  logic v, r, w, x, a, d;
  logic is_leaf, misalign, perm_ok, need_upd;

  assign v = pte[PTE_V];
  assign r = pte[PTE_R];
  assign w = pte[PTE_W];
  assign x = pte[PTE_X];
  assign a = pte[PTE_A];
  assign d = pte[PTE_D];

  assign is_leaf  = r | x;
  assign misalign = !at_l0 && (pte[PPN_LSB +: VPN_W] != '0);
  assign perm_ok  = is_store ? w : r;
  assign need_upd = !a || (is_store && !d);

  always_comb begin
    pte_new        = pte;
    pte_new[PTE_A] = 1'b1;
    if (is_store) pte_new[PTE_D] = 1'b1;

    if (!v || (w && !r))       verdict = VD_FAULT;
    else if (!is_leaf)         verdict = at_l0 ? VD_FAULT : VD_DESCEND;
    else if (misalign || !perm_ok) verdict = VD_FAULT;
    else if (need_upd)         verdict = VD_LEAF_UPD;
    else                       verdict = VD_LEAF;
  end
endmodule

// File: rtl/sv32_pa_build.sv
`timescale 1ns/1ps
module sv32_pa_build #(
  parameter int PPN_W = 22,
  parameter int VPN_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0]       leaf_ppn,
  input  logic [VPN_W+OFF_W-1:0] va_low,
  input  logic                   is_super,
  output logic [PA_W-1:0]        pa
);
  localparam int HI_W = PPN_W - VPN_W;

  always_comb begin
    if (is_super) pa = {leaf_ppn[PPN_W-1 -: HI_W], va_low};
    else          pa = {leaf_ppn, va_low[OFF_W-1:0]};
  end
endmodule

// File: rtl/sv32_walker.sv
`timescale 1ns/1ps
module sv32_walker
  import sv32_pkg::*;
#(
  parameter int PPN_W    = 22,
  parameter int VPN_W    = 10,
  parameter int OFF_W    = 12,
  parameter int PTE_BITS = 32,
  parameter int VA_W     = 2 * VPN_W + OFF_W,
  parameter int PA_W     = PPN_W + OFF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic                req_store,
  input  logic [PPN_W-1:0]    root_ppn,
  output logic                busy,
  output logic                mem_req,
  output logic                mem_we,
  output logic [PA_W-1:0]     mem_addr,
  output logic [PTE_BITS-1:0] mem_wdata,
  input  logic [PTE_BITS-1:0] mem_rdata,
  output logic                done,
  output logic                fault,
  output logic [PA_W-1:0]     paddr
);
  localparam int LEVELS  = 2;
  localparam int LOW_W   = VPN_W + OFF_W;
  localparam int PPN_LSB = PTE_BITS - PPN_W;

  walk_state_t             state_q;
  logic [LOW_W-1:0]        va_low_q;
  logic                    store_q;
  logic [PA_W-1:0]         ent_addr_q;
  logic [PTE_BITS-1:0]     pte_hold_q;
  logic [PA_W-1:0]         paddr_q;
  logic                    fault_q;

  // per-level entry address: level 1 indexes the root, level 0 the fetched table
  logic [PPN_W-1:0] tbl_ppn  [LEVELS];
  logic [VPN_W-1:0] vpn_sel  [LEVELS];
  logic [PA_W-1:0]  ent_addr [LEVELS];

  assign tbl_ppn[1] = root_ppn;
  assign vpn_sel[1] = req_vaddr[VA_W-1 -: VPN_W];
  assign tbl_ppn[0] = mem_rdata[PTE_BITS-1 -: PPN_W];
  assign vpn_sel[0] = va_low_q[LOW_W-1 -: VPN_W];

  for (genvar g = 0; g < LEVELS; g++) begin : gen_lvl
    sv32_ent_addr #(
      .PPN_W(PPN_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .PA_W(PA_W)
    ) u_ent_addr (
      .tbl_ppn (tbl_ppn[g]),
      .vpn_idx (vpn_sel[g]),
      .ent_addr(ent_addr[g])
    );
  end

  verdict_t            verdict;
  logic [PTE_BITS-1:0] pte_new;
  logic                at_l0;
  logic [PA_W-1:0]     leaf_pa;

  assign at_l0 = (state_q == S_L0_CHK);

  sv32_pte_eval #(
    .PTE_BITS(PTE_BITS), .PPN_W(PPN_W), .VPN_W(VPN_W)
  ) u_eval (
    .pte     (mem_rdata),
    .is_store(store_q),
    .at_l0   (at_l0),
    .verdict (verdict),
    .pte_new (pte_new)
  );

  sv32_pa_build #(
    .PPN_W(PPN_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .PA_W(PA_W)
  ) u_pa (
    .leaf_ppn(mem_rdata[PPN_LSB +: PPN_W]),
    .va_low  (va_low_q),
    .is_super(!at_l0),
    .pa      (leaf_pa)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      va_low_q   <= '0;
      store_q    <= 1'b0;
      ent_addr_q <= '0;
      pte_hold_q <= '0;
      paddr_q    <= '0;
      fault_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            va_low_q   <= req_vaddr[LOW_W-1:0];
            store_q    <= req_store;
            ent_addr_q <= ent_addr[1];
            fault_q    <= 1'b0;
            state_q    <= S_L1_RD;
          end
        end
        S_L1_RD: state_q <= S_L1_CHK;
        S_L0_RD: state_q <= S_L0_CHK;
        S_L1_CHK, S_L0_CHK: begin
          case (verdict)
            VD_FAULT: begin
              fault_q <= 1'b1;
              state_q <= S_DONE;
            end
            VD_DESCEND: begin
              ent_addr_q <= ent_addr[0];
              state_q    <= S_L0_RD;
            end
            VD_LEAF: begin
              paddr_q <= leaf_pa;
              state_q <= S_DONE;
            end
            default: begin
              paddr_q    <= leaf_pa;
              pte_hold_q <= pte_new;
              state_q    <= at_l0 ? S_L0_WB : S_L1_WB;
            end
          endcase
        end
        S_L1_WB, S_L0_WB: state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign mem_req   = (state_q == S_L1_RD) || (state_q == S_L0_RD) ||
                     (state_q == S_L1_WB) || (state_q == S_L0_WB);
  assign mem_we    = (state_q == S_L1_WB) || (state_q == S_L0_WB);
  assign mem_addr  = ent_addr_q;
  assign mem_wdata = pte_hold_q;
  assign done      = (state_q == S_DONE);
  assign fault     = fault_q;
  assign paddr     = paddr_q;
endmodule

// File: rtl/sv32_walker_chk.sv
`timescale 1ns/1ps
module sv32_walker_chk
  import sv32_pkg::*;
#(
  parameter int PA_W     = 34,
  parameter int PTE_BITS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_store,
  input logic                busy,
  input logic                mem_req,
  input logic                mem_we,
  input logic [PA_W-1:0]     mem_addr,
  input logic [PTE_BITS-1:0] mem_wdata,
  input logic [PTE_BITS-1:0] mem_rdata,
  input logic                done,
  input logic                fault
);
  localparam logic [PTE_BITS-1:0] AD_MASK =
    (PTE_BITS'(1) << PTE_A) | (PTE_BITS'(1) << PTE_D);

  logic                cur_store;
  logic                rd_pend;
  logic [PA_W-1:0]     last_addr;
  logic [PTE_BITS-1:0] last_pte;
  logic [2:0]          rd_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_store <= 1'b0;
      rd_pend   <= 1'b0;
      last_addr <= '0;
      last_pte  <= '0;
      rd_cnt    <= '0;
    end else begin
      if (req_valid && !busy) begin
        cur_store <= req_store;
        rd_cnt    <= '0;
      end else if (mem_req && !mem_we && rd_cnt != 3'd7) begin
        rd_cnt <= rd_cnt + 3'd1;
      end
      rd_pend <= mem_req && !mem_we;
      if (mem_req && !mem_we) last_addr <= mem_addr;
      if (rd_pend) last_pte <= mem_rdata;
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  assert_read_limit_R9: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= 3'd2);
  assert_wb_addr_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr == last_addr);
  assert_wb_only_ad_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_wdata ^ last_pte) & ~AD_MASK) == '0);
  assert_wb_sets_a_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata[PTE_A]);
  assert_load_keeps_d_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !cur_store) |-> mem_wdata[PTE_D] == last_pte[PTE_D]);
  assert_store_sets_d_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && cur_store) |-> mem_wdata[PTE_D]);
  assert_wb_needed_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata != last_pte);
  assert_wb_no_fault_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !fault);
endmodule

bind sv32_walker sv32_walker_chk #(.PA_W(PA_W), .PTE_BITS(PTE_BITS)) u_chk (.*);

// File: tb/sv32_walker_bench.sv
`timescale 1ns/1ps
module sv32_walker_bench;
  localparam int PA_W = 34;
  localparam logic [21:0] L0_PPN = 22'h2B7C9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic [21:0] root_ppn  = '0;
  logic        busy, mem_req, mem_we, done, fault;
  logic [PA_W-1:0] mem_addr, paddr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_err = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] mem [logic [PA_W-1:0]];

  always #2 clk = ~clk;

  sv32_walker u_sv32_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_store(req_store), .root_ppn(root_ppn), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .fault(fault), .paddr(paddr)
  );

  // single-port memory, read data one cycle after the strobe
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        rd_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mem(input logic [PA_W-1:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // model of the leaf/fault decision from the requirements
  function automatic void model(input logic [31:0] pte, input bit st, input bit l1,
                                output bit flt, output bit desc,
                                output logic [31:0] np);
    bit v, r, w, x;
    v = pte[0]; r = pte[1]; w = pte[2]; x = pte[3];
    flt = 0; desc = 0; np = pte;
    if (!v || (w && !r)) flt = 1;
    else if (!(r || x)) begin
      if (l1) desc = 1; else flt = 1;
    end else if (l1 && pte[19:10] != 10'h0) flt = 1;
    else if (st ? !w : !r) flt = 1;
    else np = pte | 32'h40 | (st ? 32'h80 : 32'h0);
  endfunction

  task automatic walk(input logic [31:0] va, input bit st,
                      output bit f, output logic [PA_W-1:0] pa);
    bit got;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st;
    rd_cnt = 0; wr_cnt = 0; got = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_vaddr = ~va;   // R9: must be ignored while busy
        req_store = !st;
      end
      if (k == 2) req_valid = 1'b0;
      if (done) begin
        got = 1;
        break;
      end
    end
    req_valid = 1'b0;
    f = fault; pa = paddr;
    check(got, "R9", "done seen", 64'(got), 64'd1);
    @(negedge clk);
    check(!done && !busy, "R9", "done single cycle", 64'({done, busy}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit f, flt, desc;
    logic [PA_W-1:0] pa, l1a, l0a;
    logic [31:0] va, pte, l0pte, np;
    logic [21:0] l1_ppn;
    logic [9:0] vpn1, vpn0;
    logic [11:0] off;
    int idx = 0;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!done && !busy && !fault && !mem_req, "R10", "reset outputs",
          64'({done, busy, fault, mem_req}), 64'd0);

    // Level-1 sweep: every low flag byte, both access types, aligned and misaligned
    root_ppn = 22'h0;
    for (int mis = 0; mis < 2; mis++) begin
      for (int fl = 0; fl < 256; fl++) begin
        for (int st = 0; st < 2; st++) begin
          idx++;
          vpn1 = 10'(idx * 37 + 3); vpn0 = 10'(idx * 101 + 7); off = 12'(idx * 293 + 11);
          va = {vpn1, vpn0, off};
          l1_ppn = {12'h5A3, (mis != 0) ? 10'h003 : 10'h000};
          pte = {l1_ppn, 2'b00, 8'(fl)};
          l0pte = {L0_PPN, 2'b00, 8'hCF};
          l1a = 34'(vpn1) * 4;
          l0a = 34'(l1_ppn) * 4096 + 34'(vpn0) * 4;
          mem[l1a] = pte;
          mem[l0a] = l0pte;
          model(pte, st != 0, 1'b1, flt, desc, np);
          walk(va, st != 0, f, pa);
          check(f == flt, (mis != 0) ? "R8" : "R1,R7", "level-1 fault", 64'(f), 64'(flt));
          if (desc) begin
            check(rd_cnt == 2, "R1", "two reads", 64'(rd_cnt), 64'd2);
            check(pa == {L0_PPN, off}, "R2", "base page address", 64'(pa), 64'({L0_PPN, off}));
            check(wr_cnt == 0 && rd_mem(l1a) == pte, "R6", "pointer untouched",
                  64'(rd_mem(l1a)), 64'(pte));
          end else if (!flt) begin
            check(pa == {l1_ppn[21:10], vpn0, off}, "R2", "superpage address",
                  64'(pa), 64'({l1_ppn[21:10], vpn0, off}));
            check(rd_mem(l1a) == np, "R3,R4", "level-1 entry after walk",
                  64'(rd_mem(l1a)), 64'(np));
            check(wr_cnt == ((np != pte) ? 1 : 0), "R6", "write count",
                  64'(wr_cnt), 64'((np != pte) ? 1 : 0));
          end else begin
            check(wr_cnt == 0 && rd_mem(l1a) == pte, "R6", "faulting walk writes nothing",
                  64'(wr_cnt), 64'd0);
          end
        end
      end
    end

    // Level-0 sweep: fixed pointer at level 1, every low flag byte at level 0
    for (int fl = 0; fl < 256; fl++) begin
      for (int st = 0; st < 2; st++) begin
        idx++;
        vpn1 = 10'(idx * 37 + 3); vpn0 = 10'(idx * 101 + 7); off = 12'(idx * 293 + 11);
        va = {vpn1, vpn0, off};
        l1a = 34'(vpn1) * 4;
        l0a = 34'd4096 + 34'(vpn0) * 4;
        mem[l1a] = {22'h000001, 2'b00, 8'h01};
        pte = {L0_PPN, 2'b00, 8'(fl)};
        mem[l0a] = pte;
        model(pte, st != 0, 1'b0, flt, desc, np);
        walk(va, st != 0, f, pa);
        check(f == flt, "R7,R8", "level-0 fault", 64'(f), 64'(flt));
        check(rd_cnt == 2, "R1", "two reads", 64'(rd_cnt), 64'd2);
        check(rd_mem(l0a) == np, "R3,R4", "level-0 entry after walk",
              64'(rd_mem(l0a)), 64'(np));
        check(rd_mem(l1a) == {22'h000001, 2'b00, 8'h01}, "R5", "pointer not rewritten",
              64'(rd_mem(l1a)), 64'h401);
        check(wr_cnt == ((np != pte) ? 1 : 0), "R6", "write count",
              64'(wr_cnt), 64'((np != pte) ? 1 : 0));
        if (!flt)
          check(pa == {L0_PPN, off}, "R2", "base page address", 64'(pa), 64'({L0_PPN, off}));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule